// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit logical address into a physical address. The page tables live in a word-addressed memory and have two levels. A requester presents an address, a write flag, the byte address of the outer table and an upper limit on the outer index. The walker accepts the request when it is idle.

The walker first checks the outer index against the limit. It then reads the outer table entry, which points to an inner table, and after that reads the inner table entry, which gives the frame. Both reads go through a read port that has only one read outstanding at a time. The walker checks the valid and writable flags of each entry. It ends with a single-cycle response that carries either the physical address or a fault code.

Each table entry is 32 bits wide. The frame number is in bits 31:12, the valid flag is in bit 0 and the writable flag is in bit 1. The remaining bits are ignored. The walker has no translation cache, so every request makes a full walk.

Top module: `pgwalk`

## Requirements
- R1: A successful translation returns bits 31:12 of the inner entry concatenated with logical address bits 11:0, with `rspFault` low.
- R2: The first read starts in the cycle after acceptance, at byte address `tableBase` + 4 × (logical bits 31:22). `memRdEn` is high for exactly one cycle per read.
- R3: After a valid outer entry comes back, the second read starts in the next cycle, at byte address {outer entry bits 31:12, 12'h000} + 4 × (logical bits 21:12). There are never more than two reads per request, and the outer read always comes before the inner read.
- R4: If logical bits 31:22 are greater than `outerLimit`, the walker responds with code 0 (length) in the cycle after acceptance and makes no memory read.
- R5: An outer entry with bit 0 clear gives code 1 (outer invalid), and no second read is made.
- R6: An inner entry with bit 0 clear gives code 2 (inner invalid).
- R7: A write whose inner entry has bit 1 clear gives code 3 (write protection). A read of that same page translates normally.
- R8: `busy` is high from the cycle after acceptance through the response cycle. `reqReady` is the inverse of `busy`. `rspValid` is high for exactly one cycle per request.
- R9: After reset the walker is idle: `reqReady` is high, and `busy`, `rspValid` and `memRdEn` are low.
- R10: A fault response sets `rspFault` and drives `rspPhys` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request; accepted when reqReady is high |
| reqReady | output | 1 | Walker is idle and can accept a request |
| reqAddr | input | 32 | Logical address |
| reqWrite | input | 1 | Access is a write |
| tableBase | input | 32 | Byte address of the outer table |
| outerLimit | input | 10 | Largest permitted outer index |
| busy | output | 1 | Walk in progress, including the response cycle |
| memRdEn | output | 1 | One-cycle table read strobe |
| memAddr | output | 32 | Byte address of the table read |
| memRspValid | input | 1 | Read data is valid this cycle |
| memRspData | input | 32 | Table entry read from memory |
| rspValid | output | 1 | Response strobe |
| rspPhys | output | 32 | Physical address (zero on fault) |
| rspFault | output | 1 | Response is a fault |
| rspCode | output | 2 | Fault kind: 0 length, 1 outer invalid, 2 inner invalid, 3 write protection |

## Verification
Count edges from the acceptance edge, taken as edge 0, with a memory latency of L cycles. The first read strobe appears right after edge 0. A length fault responds right after edge 0. An outer-invalid fault responds after edge L+1. The inner read strobe appears after edge L+1, and a full walk responds after edge 2L+2. The bench derives these edge numbers from its own model of the request and the table contents. At every falling edge it compares the strobes, the busy and ready flags and the read address against the values expected for that edge. It checks the response fields only at the predicted response edge, and it repeats runs with latencies of 1, 2 and 3 cycles.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W      = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int PTE_BYTES = 4;
  localparam int PTE_SH    = $clog2(PTE_BYTES);
  localparam int FRAME_W   = VA_W - OFF_W;

  typedef enum logic [1:0] {
    FLT_LEN   = 2'd0,
    FLT_OUTER = 2'd1,
    FLT_INNER = 2'd2,
    FLT_WPROT = 2'd3
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   takeOuter;
    logic   takeInner;
    logic   innerPhase;
    logic   setFault;
    fault_e code;
  } ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic lenBad;
    logic pteValid;
    logic pteWritable;
    logic isWrite;
  } sts_t;
endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic memRspValid,
  input  sts_t sts,
  output logic reqReady,
  output logic busy,
  output logic rspValid,
  output logic memRdEn,
  output ctl_t ctl
);
  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2, S_RESP} st_e;
  st_e st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    ctl    = '0;
    case (st)
      S_IDLE: if (reqValid) begin
        ctl.capture = 1'b1;
        if (sts.lenBad) begin
          ctl.setFault = 1'b1;
          ctl.code     = FLT_LEN;
          stNext       = S_RESP;
        end else begin
          stNext = S_RD1;
        end
      end
      S_RD1: stNext = S_WT1;
      S_WT1: if (memRspValid) begin
        if (!sts.pteValid) begin
          ctl.setFault = 1'b1;
          ctl.code     = FLT_OUTER;
          stNext       = S_RESP;
        end else begin
          ctl.takeOuter = 1'b1;
          stNext        = S_RD2;
        end
      end
      S_RD2: begin
        ctl.innerPhase = 1'b1;
        stNext         = S_WT2;
      end
      S_WT2: begin
        ctl.innerPhase = 1'b1;
        if (memRspValid) begin
          stNext = S_RESP;
          if (!sts.pteValid) begin
            ctl.setFault = 1'b1;
            ctl.code     = FLT_INNER;
          end else if (sts.isWrite && !sts.pteWritable) begin
            ctl.setFault = 1'b1;
            ctl.code     = FLT_WPROT;
          end else begin
            ctl.takeInner = 1'b1;
          end
        end
      end
      S_RESP:  stNext = S_IDLE;
      default: stNext = S_IDLE;
    endcase
  end

  assign reqReady = (st == S_IDLE);
  assign busy     = (st != S_IDLE);
  assign rspValid = (st == S_RESP);
  assign memRdEn  = (st == S_RD1) || (st == S_RD2);

  // R2: each read strobe lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);
  // R8: one response cycle, then idle
  a_r8_rsp_once: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));
  // R4: length fault answers at once, without a read
  a_r4_len_fast: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && sts.lenBad) |=> (rspValid && !memRdEn));
  // R5: invalid outer entry ends the walk
  a_r5_no_second: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_WT1 && memRspValid && !sts.pteValid) |=> (rspValid && !memRdEn));
  // R3: valid outer entry triggers the inner read next cycle
  a_r3_order: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_WT1 && memRspValid && sts.pteValid) |=> memRdEn);
endmodule

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic             reqWrite,
  input  logic [VA_W-1:0]  tableBase,
  input  logic [IDX_W-1:0] outerLimit,
  input  logic [VA_W-1:0]  memRspData,
  input  ctl_t             ctl,
  output sts_t             sts,
  output logic [VA_W-1:0]  memAddr,
  output logic [VA_W-1:0]  rspPhys,
  output logic             rspFault,
  output logic [1:0]       rspCode
);
  localparam int PAD_W = VA_W - IDX_W - PTE_SH;

  logic [VA_W-1:0]    vaQ, baseQ, physQ;
  logic [FRAME_W-1:0] innerBaseQ;
  logic               wrQ, faultQ;
  fault_e             codeQ;
  logic [IDX_W-1:0]   outerIdx, innerIdx;
  logic [VA_W-1:0]    outerOff, innerOff;
  logic               unusedResvBits;

  assign outerIdx = vaQ[VA_W-1 -: IDX_W];
  assign innerIdx = vaQ[OFF_W +: IDX_W];
  assign outerOff = {{PAD_W{1'b0}}, outerIdx, {PTE_SH{1'b0}}};
  assign innerOff = {{PAD_W{1'b0}}, innerIdx, {PTE_SH{1'b0}}};
  assign memAddr  = ctl.innerPhase ? ({innerBaseQ, {OFF_W{1'b0}}} + innerOff)
                                   : (baseQ + outerOff);

  assign sts.lenBad      = reqAddr[VA_W-1 -: IDX_W] > outerLimit;
  assign sts.pteValid    = memRspData[0];
  assign sts.pteWritable = memRspData[1];
  assign sts.isWrite     = wrQ;
  assign unusedResvBits  = ^memRspData[OFF_W-1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ <= '0; baseQ <= '0; wrQ <= 1'b0; innerBaseQ <= '0;
      physQ <= '0; faultQ <= 1'b0; codeQ <= FLT_LEN;
    end else begin
      if (ctl.capture) begin
        vaQ    <= reqAddr;
        wrQ    <= reqWrite;
        baseQ  <= tableBase;
        faultQ <= 1'b0;
        physQ  <= '0;
      end
      if (ctl.takeOuter) innerBaseQ <= memRspData[VA_W-1:OFF_W];
      if (ctl.takeInner) physQ <= {memRspData[VA_W-1:OFF_W], vaQ[OFF_W-1:0]};
      if (ctl.setFault) begin
        faultQ <= 1'b1;
        codeQ  <= ctl.code;
        physQ  <= '0;
      end
    end
  end

  assign rspPhys  = physQ;
  assign rspFault = faultQ;
  assign rspCode  = codeQ;

  // R1: translated page offset follows the logical offset
  a_r1_offset: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeInner |=> (rspPhys[OFF_W-1:0] == vaQ[OFF_W-1:0] && !rspFault));
  // R10: a fault clears the physical address
  a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setFault |=> (rspFault && rspPhys == '0));
endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic             reqWrite,
  input  logic [VA_W-1:0]  tableBase,
  input  logic [IDX_W-1:0] outerLimit,
  output logic             busy,
  output logic             memRdEn,
  output logic [VA_W-1:0]  memAddr,
  input  logic             memRspValid,
  input  logic [VA_W-1:0]  memRspData,
  output logic             rspValid,
  output logic [VA_W-1:0]  rspPhys,
  output logic             rspFault,
  output logic [1:0]       rspCode
);
  ctl_t ctl;
  sts_t sts;

  pgwalk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .sts(sts), .reqReady(reqReady), .busy(busy), .rspValid(rspValid),
    .memRdEn(memRdEn), .ctl(ctl)
  );

  pgwalk_dp u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .tableBase(tableBase), .outerLimit(outerLimit), .memRspData(memRspData),
    .ctl(ctl), .sts(sts), .memAddr(memAddr), .rspPhys(rspPhys),
    .rspFault(rspFault), .rspCode(rspCode)
  );

  // R8: ready and busy are complementary whenever out of reset
  a_r8_ready_busy: assert property (@(posedge clk) disable iff (!rstN)
    reqReady != busy);
endmodule

// File: tb/pgwalk_bench.sv
`timescale 1ns/1ps
module pgwalk_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, tableBase = 32'h0001_0000;
  logic [9:0]  outerLimit = 10'd8;
  logic        reqReady, busy, memRdEn, memRspValid, rspValid, rspFault;
  logic [31:0] memAddr, memRspData, rspPhys;
  logic [1:0]  rspCode;

  always #2.5 clk = ~clk;

  pgwalk u_pgwalk (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .tableBase(tableBase),
    .outerLimit(outerLimit), .busy(busy), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .rspValid(rspValid),
    .rspPhys(rspPhys), .rspFault(rspFault), .rspCode(rspCode)
  );

  // behavioural table memory with programmable latency
  bit [31:0] mem [bit [31:0]];
  int        lat = 1;
  int        memCnt = 0;
  logic [31:0] memDat = '0;

  function automatic bit [31:0] memRd(bit [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      memCnt <= lat;
      memDat <= memRd(memAddr);
    end else if (memCnt > 0) begin
      memCnt <= memCnt - 1;
    end
  end
  assign memRspValid = (memCnt == 1);
  assign memRspData  = memDat;

  int nVec = 0, nBad = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkva(int o, int i, int off);
    return {o[9:0], i[9:0], off[11:0]};
  endfunction

  // reference model: expected response edge, code, reads
  task automatic walk(logic [31:0] va, bit wr, int latency, string req);
    int e, respEdge, nReads, code;
    bit [31:0] a1, a2, e1, e2, phys;
    lat = latency;
    a1 = '0; a2 = '0; phys = '0; code = -1; nReads = 0;
    if (va[31:22] > outerLimit) begin
      code = 0; respEdge = 0;
    end else begin
      a1 = tableBase + {20'd0, va[31:22], 2'b00};
      e1 = memRd(a1); nReads = 1;
      if (!e1[0]) begin
        code = 1; respEdge = 1 + latency;
      end else begin
        a2 = {e1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
        e2 = memRd(a2); nReads = 2; respEdge = 2 + 2 * latency;
        if (!e2[0]) code = 2;
        else if (wr && !e2[1]) code = 3;
        else phys = {e2[31:12], va[11:0]};
      end
    end
    @(negedge clk);
    chk(reqReady, "R8", "ready before request", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqAddr = va; reqWrite = wr;
    @(posedge clk);
    for (e = 0; e <= respEdge + 1; e++) begin
      @(negedge clk);
      reqValid = 1'b0;
      chk(busy == (e <= respEdge), "R8", "busy", {31'd0, busy}, {31'd0, e <= respEdge});
      chk(reqReady == (e > respEdge), "R8", "reqReady", {31'd0, reqReady}, {31'd0, e > respEdge});
      chk(rspValid == (e == respEdge), "R8", "rspValid", {31'd0, rspValid}, {31'd0, e == respEdge});
      if (e == 0) begin
        chk(memRdEn == (nReads >= 1), (nReads == 0) ? "R4" : "R2", "first read strobe",
            {31'd0, memRdEn}, {31'd0, nReads >= 1});
        if (nReads >= 1) chk(memAddr == a1, "R2", "outer read address", memAddr, a1);
      end else if (e == latency + 1) begin
        chk(memRdEn == (nReads == 2), (nReads == 2) ? "R3" : "R5", "second read strobe",
            {31'd0, memRdEn}, {31'd0, nReads == 2});
        if (nReads == 2) chk(memAddr == a2, "R3", "inner read address", memAddr, a2);
      end else begin
        chk(!memRdEn, "R3", "no extra read", {31'd0, memRdEn}, 32'd0);
      end
      if (e == respEdge) begin
        chk(rspFault == (code >= 0), req, "rspFault", {31'd0, rspFault}, {31'd0, code >= 0});
        if (code >= 0) begin
          chk(rspCode == code[1:0], req, "rspCode", {30'd0, rspCode}, code);
          chk(rspPhys == 32'd0, "R10", "phys on fault", rspPhys, 32'd0);
        end else begin
          chk(rspPhys == phys, req, "rspPhys", rspPhys, phys);
        end
      end
      @(posedge clk);
    end
  endtask

  initial begin
    mem[32'h0001_0000] = 32'h0002_0003;  // outer 0 -> inner table 0x20000
    mem[32'h0001_000C] = 32'h0003_0002;  // outer 3 invalid
    mem[32'h0001_0020] = 32'h0004_0001;  // outer 8 -> inner table 0x40000
    mem[32'h0002_0014] = 32'hABCD_E003;  // inner 5 rw
    mem[32'h0002_0018] = 32'h1234_5001;  // inner 6 read-only
    mem[32'h0002_001C] = 32'h5555_5002;  // inner 7 invalid
    mem[32'h0004_0000] = 32'h0BEE_F003;  // inner 0 rw, reserved bits clear
    mem[32'h0004_0004] = 32'h0777_7FF3;  // inner 1 rw, reserved bits set
    repeat (3) @(negedge clk);
    chk(reqReady && !busy && !rspValid && !memRdEn, "R9", "idle in reset",
        {28'd0, reqReady, busy, rspValid, memRdEn}, 32'h8);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !busy && !rspValid && !memRdEn, "R9", "idle after reset",
        {28'd0, reqReady, busy, rspValid, memRdEn}, 32'h8);

    walk(mkva(0, 5, 'h123), 1'b0, 1, "R1");
    walk(mkva(0, 5, 'hFFF), 1'b1, 3, "R1");
    walk(mkva(0, 6, 'h456), 1'b0, 2, "R7");
    walk(mkva(0, 6, 'h456), 1'b1, 1, "R7");
    walk(mkva(0, 7, 'h001), 1'b0, 2, "R6");
    walk(mkva(3, 2, 'h010), 1'b0, 2, "R5");
    walk(mkva(3, 2, 'h010), 1'b1, 1, "R5");
    walk(mkva(9, 0, 'h000), 1'b0, 1, "R4");
    walk(mkva(1023, 1023, 'hFFF), 1'b1, 2, "R4");
    walk(mkva(8, 0, 'hABC), 1'b1, 3, "R1");
    walk(mkva(8, 1, 'h00F), 1'b0, 1, "R1");
    walk(mkva(8, 3, 'h00F), 1'b0, 1, "R6");
    outerLimit = 10'd0;
    walk(mkva(8, 0, 'h000), 1'b0, 1, "R4");
    walk(mkva(0, 5, 'h777), 1'b0, 2, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule